// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives serial words while acting as clock master on a two-wire synchronous link. It generates the serial clock itself from a programmable divisor. It samples the data line on each falling edge of that clock and shifts the bits in least significant bit first. Words are 8 bits wide, or 9 bits wide when the ninth-bit mode is on. Each finished word moves into a two-entry receive FIFO, and the host pops entries from that FIFO with a read strobe.

The host can start reception in two ways. A one-shot request takes exactly one word and then withdraws itself. A level enable keeps taking words back to back for as long as it is held. If the FIFO is full when a word finishes, an overrun flag latches and the word is lost. While the flag is set, no further words are loaded. The flag clears only when the level enable goes from high to low. A ready flag shows that the FIFO holds data, and the interrupt output is that flag gated by an interrupt enable.

Top module: `sync_rx_master`

## Requirements
- R1: After reset, sck is 0, rx_ready, irq, overrun and single_busy are 0, and rd_data and rd_bit9 are 0.
- R2: While a reception is active, sck is a square wave with a period of 4*(divisor+1) clk cycles. sck is held at 0 whenever neither cont_en nor single_busy is set.
- R3: sdi is sampled on each falling edge of sck, with the first sampled bit landing in bit 0 of the word. In 8-bit mode (nine_bit_en=0), a word is 8 samples and rd_bit9 reads 0 for that entry.
- R4: A single_set pulse sets single_busy. In single mode (cont_en=0), exactly one word is received, then single_busy clears and sck stays low.
- R5: While cont_en is 1, words are received back to back with no gap in sck. Clearing cont_en stops the clock.
- R6: When cont_en and single_busy are both set, continuous mode takes precedence: words keep arriving and single_busy stays 1. After cont_en is cleared at a word boundary, the pending single request receives one more word.
- R7: The FIFO holds two entries in arrival order. rd_data and rd_bit9 show the oldest entry, and a rd_pop pulse removes it.
- R8: A word that finishes while the FIFO holds two entries sets overrun and is discarded. The FIFO contents are unchanged.
- R9: While overrun is 1, no finished word enters the FIFO, even when the FIFO has room. A 1-to-0 transition of cont_en clears overrun.
- R10: rx_ready is 1 whenever the FIFO holds at least one entry. It returns to 0 only after pops have emptied the FIFO.
- R11: irq equals rx_ready AND irq_en.
- R12: With nine_bit_en=1, a word is 9 samples. The ninth sample is stored with its entry and appears on rd_bit9 while that entry is the oldest.
- R13: A rd_pop pulse while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cont_en | input | 1 | Continuous receive enable (level) |
| single_set | input | 1 | Pulse requesting a single-word reception |
| nine_bit_en | input | 1 | Selects 9-bit words |
| irq_en | input | 1 | Interrupt enable |
| divisor | input | DIV_W | Serial clock divisor |
| rd_pop | input | 1 | Data read strobe, pops the oldest entry |
| rd_data | output | 8 | Data byte of the oldest FIFO entry |
| rd_bit9 | output | 1 | Ninth bit of the oldest FIFO entry |
| rx_ready | output | 1 | FIFO not empty |
| overrun | output | 1 | Overrun flag |
| single_busy | output | 1 | Single-word request pending |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock output |
| sdi | input | 1 | Serial data input |

## Verification
The hardest state to reach is overrun while reads have freed room in the FIFO. That state shows whether the latched flag, rather than FIFO occupancy, blocks the load. The stimulus gets there by streaming four words in continuous mode with no reads, then popping both entries while cont_en stays high and streaming a fifth word. Only then does it release cont_en at a word boundary. A serial slave model in the bench drives each new bit on the rising edge of sck, and it counts falling edges so that enables change exactly between words.

// File: rtl/sync_rx_master.sv
module sync_rx_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cont_en,
  input  logic             single_set,
  input  logic             nine_bit_en,
  input  logic             irq_en,
  input  logic [DIV_W-1:0] divisor,
  input  logic             rd_pop,
  output logic [7:0]       rd_data,
  output logic             rd_bit9,
  output logic             rx_ready,
  output logic             overrun,
  output logic             single_busy,
  output logic             irq,
  output logic             sck,
  input  logic             sdi
);
  localparam int HW = DIV_W + 1;

  logic [HW-1:0] hcnt;
  logic          sck_q, single_q, ovr_q, cont_q;
  logic [3:0]    bitcnt;
  logic [8:0]    shreg;
  logic [8:0]    mem [2];
  logic          head;
  logic [1:0]    count;

  wire [HW-1:0] hlim = {divisor, 1'b1};
  wire active    = cont_en | single_q;
  wire tick      = active && (hcnt == hlim);
  wire fall      = tick && sck_q;
  wire last      = bitcnt == (nine_bit_en ? 4'd8 : 4'd7);
  wire word_done = fall && last;
  wire [8:0] shin = {sdi, shreg[8:1]};
  wire [8:0] wword = nine_bit_en ? shin : {1'b0, shin[8:1]};
  wire pop  = rd_pop && (count != 2'd0);
  wire push = word_done && !ovr_q && (count != 2'd2);
  wire wr_idx = head ^ count[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt   <= '0;
      sck_q  <= 1'b0;
      bitcnt <= '0;
      shreg  <= '0;
    end else if (!active) begin
      hcnt   <= '0;
      sck_q  <= 1'b0;
      bitcnt <= '0;
    end else if (tick) begin
      hcnt  <= '0;
      sck_q <= ~sck_q;
      if (sck_q) begin
        shreg  <= shin;
        bitcnt <= last ? 4'd0 : bitcnt + 4'd1;
      end
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_q <= 1'b0;
      ovr_q    <= 1'b0;
      cont_q   <= 1'b0;
    end else begin
      cont_q <= cont_en;
      if (single_set)
        single_q <= 1'b1;
      else if (word_done && !cont_en)
        single_q <= 1'b0;
      if (cont_q && !cont_en)
        ovr_q <= 1'b0;
      else if (word_done && !ovr_q && count == 2'd2)
        ovr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem[0] <= '0;
      mem[1] <= '0;
      head   <= 1'b0;
      count  <= '0;
    end else begin
      if (push) mem[wr_idx] <= wword;
      if (pop)  head <= ~head;
      count <= count + {1'b0, push} - {1'b0, pop};
    end
  end

  assign rd_data     = mem[head][7:0];
  assign rd_bit9     = mem[head][8];
  assign rx_ready    = count != 2'd0;
  assign overrun     = ovr_q;
  assign single_busy = single_q;
  assign irq         = rx_ready & irq_en;
  assign sck         = sck_q;

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cont_en || single_q) |=> !sck);
  assert_fifo_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= 2'd2);
  assert_ovr_no_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> count <= $past(count));
  assert_ready_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> $past(rd_pop));
  assert_single_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(single_busy) |-> !$past(cont_en) && !$past(single_set));
  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

// File: tb/sync_rx_master_test.sv
`timescale 1ns/1ps
module sync_rx_master_test;
  logic clk = 0, rst_n = 0;
  logic cont_en = 0, single_set = 0, nine_bit_en = 0, irq_en = 0, rd_pop = 0, sdi = 0;
  logic [7:0] divisor = 0;
  logic [7:0] rd_data;
  logic rd_bit9, rx_ready, overrun, single_busy, irq, sck;

  sync_rx_master #(.DIV_W(8)) uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  int cyc = 0, nfall = 0, sidx = 0, base_i = 0, last_rise = 0, last_period = 0, nrise = 0;
  logic sck_prev = 0;
  logic [63:0] stream = '0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    sck_prev <= sck;
    if (sck && !sck_prev) begin
      sdi <= stream[sidx - base_i];
      sidx <= sidx + 1;
      nrise <= nrise + 1;
      last_period <= cyc - last_rise;
      last_rise <= cyc;
    end
    if (!sck && sck_prev) nfall <= nfall + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_stream(input logic [63:0] s, output int fbase);
    @(negedge clk);
    stream = s;
    base_i = sidx;
    fbase = nfall;
  endtask

  task automatic wait_falls(input int target);
    while (nfall < target) @(negedge clk);
  endtask

  task automatic pulse_single();
    @(negedge clk); single_set = 1;
    @(negedge clk); single_set = 0;
  endtask

  task automatic pop();
    @(negedge clk); rd_pop = 1;
    @(negedge clk); rd_pop = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int fb, f0;
    logic [7:0] w;
    repeat (3) @(negedge clk);
    chk(sck == 0 && rx_ready == 0 && irq == 0 && overrun == 0 && single_busy == 0 &&
        rd_data == 0 && rd_bit9 == 0, "R1 reset", {rx_ready, overrun, single_busy, sck}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R11: single 8-bit words swept over divisors and data
    for (int d = 0; d < 4; d++) begin
      for (int k = 0; k < 8; k++) begin
        divisor = d[7:0];
        w = 8'((k * 37 + d * 11 + 1) & 255);
        irq_en = k[0];
        start_stream({56'h0, w}, fb);
        pulse_single();
        wait_falls(fb + 8);
        @(negedge clk);
        chk(rd_data == w, "R3 data", rd_data, w);
        chk(rd_bit9 == 0, "R3 bit9 in 8-bit mode", rd_bit9, 0);
        chk(rx_ready == 1, "R10 ready set", rx_ready, 1);
        chk(irq == (irq_en & 1'b1), "R11 irq gate", irq, irq_en);
        chk(last_period == 4 * (d + 1), "R2 period", last_period, 4 * (d + 1));
        chk(single_busy == 0, "R4 single self-clear", single_busy, 0);
        f0 = nfall;
        repeat (40) @(negedge clk);
        chk(nfall == f0 && sck == 0, "R4 clock stops", nfall - f0, 0);
        pop();
        chk(rx_ready == 0 && irq == 0, "R10 ready cleared by pop", rx_ready, 0);
      end
    end

    // R13: pop on empty FIFO, then a word still lands correctly
    pop();
    chk(rx_ready == 0, "R13 empty pop ignored", rx_ready, 0);
    divisor = 1;
    start_stream({56'h0, 8'h5A}, fb);
    pulse_single();
    wait_falls(fb + 8);
    @(negedge clk);
    chk(rd_data == 8'h5A && rx_ready == 1, "R13 after empty pop", rd_data, 8'h5A);
    pop();

    // R12: 9-bit continuous, two words
    divisor = 2;
    nine_bit_en = 1;
    start_stream({46'h0, 9'h03C, 9'h1A5}, fb);
    cont_en = 1;
    wait_falls(fb + 18);
    cont_en = 0;
    @(negedge clk);
    chk(rd_data == 8'hA5 && rd_bit9 == 1, "R12 first entry bit9", {rd_bit9, rd_data}, 9'h1A5);
    pop();
    chk(rd_data == 8'h3C && rd_bit9 == 0, "R12 bit9 follows pop", {rd_bit9, rd_data}, 9'h03C);
    chk(rx_ready == 1, "R10 ready held with one entry", rx_ready, 1);
    pop();
    chk(rx_ready == 0, "R10 ready after second pop", rx_ready, 0);
    f0 = nfall;
    repeat (40) @(negedge clk);
    chk(nfall == f0 && sck == 0, "R5 clock stops on cont clear", nfall - f0, 0);
    nine_bit_en = 0;

    // R5 R7 R8 R9: overrun sequence
    divisor = 1;
    start_stream({24'h0, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11}, fb);
    cont_en = 1;
    wait_falls(fb + 16);
    @(negedge clk);
    chk(rd_data == 8'h11 && overrun == 0, "R5 back to back", rd_data, 8'h11);
    wait_falls(fb + 24);
    @(negedge clk);
    chk(overrun == 1, "R8 overrun set", overrun, 1);
    chk(rd_data == 8'h11, "R8 fifo unchanged", rd_data, 8'h11);
    wait_falls(fb + 32);
    pop();
    chk(rd_data == 8'h22, "R7 fifo order", rd_data, 8'h22);
    pop();
    chk(rx_ready == 0, "R8 third/fourth word discarded", rx_ready, 0);
    wait_falls(fb + 40);
    @(negedge clk);
    chk(rx_ready == 0 && overrun == 1, "R9 load blocked while overrun", rx_ready, 0);
    cont_en = 0;
    repeat (2) @(negedge clk);
    chk(overrun == 0, "R9 overrun cleared by cont fall", overrun, 0);

    // R6: precedence with both enables
    start_stream({40'h0, 8'hC3, 8'hB2, 8'hA1}, fb);
    cont_en = 1;
    pulse_single();
    wait_falls(fb + 16);
    @(negedge clk);
    chk(single_busy == 1, "R6 single stays set under cont", single_busy, 1);
    chk(rd_data == 8'hA1, "R6 first word", rd_data, 8'hA1);
    pop();
    chk(rd_data == 8'hB2, "R6 second word", rd_data, 8'hB2);
    pop();
    cont_en = 0;
    wait_falls(fb + 24);
    @(negedge clk);
    chk(rd_data == 8'hC3 && single_busy == 0, "R6 single finishes after cont", rd_data, 8'hC3);
    f0 = nfall;
    repeat (40) @(negedge clk);
    chk(nfall == f0, "R4 stop after precedence", nfall - f0, 0);
    pop();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule